// File: doc/BRIEF.md
# Flash Memory Controller with Erase Engine

This block is a controller for a word-addressed storage array that behaves like NOR flash, together with a small store of user-configuration words. A 32-bit register port holds a two-bit configuration register (program enable and erase enable), a ready flag and three erase command registers. A separate word port programs storage, and a third port reads and writes the user-configuration words. Storage read data comes from a synchronous read port that never stalls.

Programming works like NOR flash. It can only clear bits: the stored word becomes the old word ANDed with the new data. Erases return words to all ones. An erase runs as a sweep that writes one word per cycle from an address counter, so the array stays a simple RAM that block RAM can hold. While a sweep runs, the ready flag reads 0, and new erase commands and storage programs are dropped. Erase-all also wipes the user-configuration store. A user-configuration erase needs no erase enable.

Top module: `nvm_flash_ctrl`

## Requirements
- R1: Register offsets are: ready 0x400, configuration 0x504, page erase 0x508, erase-all 0x50C, user-config erase 0x514. In the configuration register, bit 0 is program enable and bit 1 is erase enable. A write keeps only those two bits, and a read returns them with all other bits zero. Register read data appears in the cycle after the request and is zero when no read was made.
- R2: While program enable is set, a storage write makes the stored word equal to the old word AND the written data. This also holds for back-to-back writes to the same word. The result is visible on the read port from the second cycle after the write.
- R3: A storage write while program enable is clear leaves storage unchanged and pulses `st_err` high in the next cycle.
- R4: A write to the page-erase register while erase enable is set clears the in-page offset bits of the written byte address and fills that whole page with ones. Words outside the page are unchanged. With erase enable clear, the write does nothing.
- R5: A page-erase byte address at or beyond the end of storage (page count times page bytes) is ignored, and the ready flag stays 1.
- R6: Writing the value 1 to the erase-all register while erase enable is set fills all storage and all user-configuration words with ones. Any other value, or erase enable clear, does nothing.
- R7: Writing the value 1 to the user-config erase register sets every user-configuration word to all ones, whether or not erase enable is set. Any other value does nothing.
- R8: The ready register reads 1 when idle and 0 while an erase sweep runs. Storage writes and all three erase commands that arrive during a sweep are ignored. A storage write accepted in the same cycle as an erase command is applied first.
- R9: Reset clears the configuration register and sets all user-configuration words to ones. Storage contents survive reset.
- R10: The 64 user-configuration words can each be written, and read back one cycle after a read request. The read data is zero when no read was made.
- R11: A read of any offset other than ready or configuration returns zero. A write to any offset other than the configuration register and the three erase registers is dropped. Both pulse `reg_err` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | Register access is a write |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered register read data |
| reg_err | output | 1 | Undefined register access pulse |
| st_we | input | 1 | Storage program request |
| st_addr | input | WAW (11) | Storage word address for programming |
| st_wdata | input | 32 | Storage program data |
| st_err | output | 1 | Program attempted while locked |
| st_raddr | input | WAW (11) | Storage read word address |
| st_rdata | output | 32 | Registered storage read data |
| uc_en | input | 1 | User-config access request |
| uc_we | input | 1 | User-config access is a write |
| uc_addr | input | UAW (6) | User-config word index |
| uc_wdata | input | 32 | User-config write data |
| uc_rdata | output | 32 | Registered user-config read data |

## Verification
The hardest case to reach is a storage program that lands in the same cycle as an accepted erase command. In that case the program's read-modify-write has to finish before the sweep starts. A close second is a run of programs to one word on consecutive cycles, where each read returns data that the previous write has not yet updated. The stimulus reaches the first case by driving the program port and the erase register port in the same cycle, once with the word inside the erased page and once outside it. It reaches the second by issuing programs to one address on consecutive cycles. A behavioural model applies each effect in acceptance order and counts down the sweep length, so the ready flag and every idle storage read are compared cycle by cycle.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [11:0] OFS_READY = 12'h400;
  localparam logic [11:0] OFS_CFG   = 12'h504;
  localparam logic [11:0] OFS_ERPG  = 12'h508;
  localparam logic [11:0] OFS_ERALL = 12'h50C;
  localparam logic [11:0] OFS_ERUC  = 12'h514;
  localparam logic [31:0] ERASE_KEY = 32'd1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_READY, SEL_CFG, SEL_ERPG, SEL_ERALL, SEL_ERUC
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [11:0] ofs);
    case (ofs)
      OFS_READY: return SEL_READY;
      OFS_CFG:   return SEL_CFG;
      OFS_ERPG:  return SEL_ERPG;
      OFS_ERALL: return SEL_ERALL;
      OFS_ERUC:  return SEL_ERUC;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          w_en,
  input  logic [AW-1:0] w_addr,
  input  logic [DW-1:0] w_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (w_en) mem[w_addr] <= w_data;
  end

  always_ff @(posedge clk) begin
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/nvm_ucfg.sv
module nvm_ucfg #(
  parameter int DW    = 32,
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wipe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] words [WORDS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (rst || wipe) words[i] <= '1;
      else if (wr_en && wr_addr == AW'(i)) words[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_en ? words[rd_addr] : '0;
  end

  // R7 / R6: a wipe leaves the first and last word at all ones
  a_r7_wipe_ones: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (words[0] == '1 && words[WORDS-1] == '1));
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int PAGE_BYTES = 1024,
  parameter int NUM_PAGES  = 8,
  localparam int PAGE_WORDS = PAGE_BYTES / 4,
  localparam int DEPTH      = PAGE_WORDS * NUM_PAGES,
  localparam int WAW        = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_en,
  input  logic           reg_we,
  input  logic [11:0]    reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           reg_err,
  input  logic           stall,
  output logic           cfg_wen,
  output logic           cfg_een,
  output logic           busy,
  output logic           sweep_we,
  output logic [WAW-1:0] sweep_addr,
  output logic           uc_wipe
);
  localparam int PB_LOG2 = $clog2(PAGE_BYTES);
  localparam int PW_LOG2 = $clog2(PAGE_WORDS);
  localparam int PG_AW   = WAW - PW_LOG2;
  localparam logic [31:0] SPAN = 32'(DEPTH) * 32'd4;

  reg_sel_e       sel;
  logic           rd, wr, key_ok, pg_ok;
  logic [1:0]     cfg_q;
  logic           sweep_q;
  logic [WAW-1:0] cnt_q, last_q, pg_base;
  logic [PG_AW-1:0] pg_idx;

  assign sel     = decode_ofs(reg_addr);
  assign rd      = reg_en && !reg_we;
  assign wr      = reg_en && reg_we;
  assign key_ok  = (reg_wdata == ERASE_KEY);
  assign pg_ok   = (reg_wdata < SPAN);
  assign pg_idx  = reg_wdata[PB_LOG2 +: PG_AW];
  assign pg_base = {pg_idx, {PW_LOG2{1'b0}}};

  assign cfg_wen    = cfg_q[0];
  assign cfg_een    = cfg_q[1];
  assign busy       = sweep_q;
  assign sweep_we   = sweep_q && !stall;
  assign sweep_addr = cnt_q;
  assign uc_wipe    = wr && !sweep_q && key_ok &&
                      (sel == SEL_ERUC || (sel == SEL_ERALL && cfg_q[1]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      sweep_q   <= 1'b0;
      cnt_q     <= '0;
      last_q    <= '0;
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
      if (rd) begin
        case (sel)
          SEL_READY: reg_rdata <= {31'd0, ~sweep_q};
          SEL_CFG:   reg_rdata <= {30'd0, cfg_q};
          default:   reg_err   <= 1'b1;
        endcase
      end
      if (sweep_q) begin
        if (!stall) begin
          cnt_q <= cnt_q + WAW'(1);
          if (cnt_q == last_q) sweep_q <= 1'b0;
        end
      end else if (wr && cfg_q[1]) begin
        if (sel == SEL_ERPG && pg_ok) begin
          sweep_q <= 1'b1;
          cnt_q   <= pg_base;
          last_q  <= pg_base + WAW'(PAGE_WORDS - 1);
        end else if (sel == SEL_ERALL && key_ok) begin
          sweep_q <= 1'b1;
          cnt_q   <= '0;
          last_q  <= WAW'(DEPTH - 1);
        end
      end
      if (wr) begin
        case (sel)
          SEL_CFG:  cfg_q <= reg_wdata[1:0];
          SEL_ERPG, SEL_ERALL, SEL_ERUC: ;
          default:  reg_err <= 1'b1;
        endcase
      end
    end
  end

  // R1: configuration read-back carries no bits above the two fields
  a_r1_cfg_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_CFG) |=> reg_rdata[31:2] == 30'd0);
  // R8: ready reads 0 during a sweep
  a_r8_ready_low: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_READY && sweep_q) |=> reg_rdata == 32'd0);
  // R4: the sweep stops after its last word
  a_r4_sweep_ends: assert property (@(posedge clk) disable iff (rst)
    (sweep_q && !stall && cnt_q == last_q) |=> !sweep_q);
  // R5: an out-of-range page address starts nothing
  a_r5_oob_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_ERPG && !sweep_q && !pg_ok) |=> !sweep_q);
  // R11: undefined offsets raise the error pulse
  a_r11_undef_err: assert property (@(posedge clk) disable iff (rst)
    (reg_en && sel == SEL_NONE) |=> reg_err);
endmodule

// File: rtl/nvm_flash_ctrl.sv
module nvm_flash_ctrl #(
  parameter int PAGE_BYTES = 1024,
  parameter int NUM_PAGES  = 8,
  parameter int UC_WORDS   = 64,
  localparam int WAW = $clog2((PAGE_BYTES / 4) * NUM_PAGES),
  localparam int UAW = $clog2(UC_WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_en,
  input  logic           reg_we,
  input  logic [11:0]    reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           reg_err,
  input  logic           st_we,
  input  logic [WAW-1:0] st_addr,
  input  logic [31:0]    st_wdata,
  output logic           st_err,
  input  logic [WAW-1:0] st_raddr,
  output logic [31:0]    st_rdata,
  input  logic           uc_en,
  input  logic           uc_we,
  input  logic [UAW-1:0] uc_addr,
  input  logic [31:0]    uc_wdata,
  output logic [31:0]    uc_rdata
);
  localparam int DEPTH = (PAGE_BYTES / 4) * NUM_PAGES;

  logic           cfg_wen, cfg_een, busy, sweep_we, uc_wipe, prog_ok;
  logic [WAW-1:0] sweep_addr;
  logic           pend_v;
  logic [WAW-1:0] pend_addr;
  logic [31:0]    pend_mask, old_word;
  logic           mem_we;
  logic [WAW-1:0] mem_waddr;
  logic [31:0]    mem_wdata;

  nvm_ctrl #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_ctrl (
    .clk(clk), .rst(rst),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .stall(pend_v), .cfg_wen(cfg_wen), .cfg_een(cfg_een), .busy(busy),
    .sweep_we(sweep_we), .sweep_addr(sweep_addr), .uc_wipe(uc_wipe)
  );

  assign prog_ok = st_we && cfg_wen && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '1;
      st_err    <= 1'b0;
    end else begin
      pend_v <= prog_ok;
      st_err <= st_we && !cfg_wen;
      if (prog_ok) begin
        pend_addr <= st_addr;
        pend_mask <= (pend_v && pend_addr == st_addr) ? (st_wdata & pend_mask)
                                                      : st_wdata;
      end
    end
  end

  assign mem_we    = pend_v || sweep_we;
  assign mem_waddr = pend_v ? pend_addr : sweep_addr;
  assign mem_wdata = pend_v ? (old_word & pend_mask) : '1;

  nvm_store #(.DW(32), .DEPTH(DEPTH)) u_store (
    .clk(clk),
    .ra_addr(st_raddr), .ra_data(st_rdata),
    .rb_addr(st_addr),  .rb_data(old_word),
    .w_en(mem_we), .w_addr(mem_waddr), .w_data(mem_wdata)
  );

  nvm_ucfg #(.DW(32), .WORDS(UC_WORDS)) u_ucfg (
    .clk(clk), .rst(rst), .wipe(uc_wipe),
    .wr_en(uc_en && uc_we), .wr_addr(uc_addr), .wr_data(uc_wdata),
    .rd_en(uc_en && !uc_we), .rd_addr(uc_addr), .rd_data(uc_rdata)
  );

  // R3: a locked program raises st_err next cycle
  a_r3_locked_err: assert property (@(posedge clk) disable iff (rst)
    (st_we && !cfg_wen) |=> st_err);
  // R8: no program is taken while a sweep runs
  a_r8_no_prog_busy: assert property (@(posedge clk) disable iff (rst)
    (st_we && busy) |=> !pend_v);
  // R4: erase enable must be set for a sweep to begin
  a_r4_sweep_needs_een: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cfg_een) |=> !busy);
endmodule

// File: tb/tb_nvm_flash_ctrl.sv
module tb_nvm_flash_ctrl;
  localparam int PB = 1024, NP = 8, PW = PB / 4, DEPTH = PW * NP;
  localparam int WAW = 11, UAW = 6, UCW = 64;
  localparam logic [11:0] A_RDY = 12'h400, A_CFG = 12'h504, A_PG = 12'h508,
                          A_ALL = 12'h50C, A_UC = 12'h514;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_en = 0, reg_we = 0; logic [11:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata; logic reg_err;
  logic st_we = 0; logic [WAW-1:0] st_addr = 0, st_raddr = 0; logic [31:0] st_wdata = 0;
  logic st_err; logic [31:0] st_rdata;
  logic uc_en = 0, uc_we = 0; logic [UAW-1:0] uc_addr = 0; logic [31:0] uc_wdata = 0;
  logic [31:0] uc_rdata;

  always #10 clk = ~clk;

  nvm_flash_ctrl dut (
    .clk(clk), .rst(rst),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err),
    .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata), .st_err(st_err),
    .st_raddr(st_raddr), .st_rdata(st_rdata),
    .uc_en(uc_en), .uc_we(uc_we), .uc_addr(uc_addr), .uc_wdata(uc_wdata),
    .uc_rdata(uc_rdata)
  );

  int total = 0, bad = 0;
  string cur_req = "R9";

  // behavioural reference state
  logic [31:0] mem_m [DEPTH];
  logic [31:0] uc_m [UCW];
  logic [1:0]  cfg_m;
  int          left;
  bit          pend_m;
  logic [31:0] exp_rr, exp_uc, exp_st;
  bit          exp_re, exp_se, st_chk;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit busy, newpend;
    if (rst) begin
      cfg_m = 0; left = 0; pend_m = 0;
      foreach (uc_m[i]) uc_m[i] = '1;
      exp_rr = 0; exp_re = 0; exp_se = 0; exp_uc = 0; st_chk = 0;
      return;
    end
    busy   = left > 0;
    st_chk = !busy && !pend_m;
    exp_st = mem_m[st_raddr];
    exp_uc = (uc_en && !uc_we) ? uc_m[uc_addr] : 32'd0;
    exp_rr = 0; exp_re = 0;
    exp_se = st_we && !cfg_m[0];
    newpend = st_we && cfg_m[0] && !busy;
    if (newpend) mem_m[st_addr] = mem_m[st_addr] & st_wdata;
    if (uc_en && uc_we) uc_m[uc_addr] = uc_wdata;
    if (reg_en && !reg_we) begin
      if (reg_addr == A_RDY)      exp_rr = busy ? 32'd0 : 32'd1;
      else if (reg_addr == A_CFG) exp_rr = {30'd0, cfg_m};
      else                        exp_re = 1;
    end else if (reg_en) begin
      if (reg_addr == A_CFG) cfg_m = reg_wdata[1:0];
      else if (reg_addr == A_PG) begin
        if (!busy && cfg_m[1] && reg_wdata < DEPTH * 4) begin
          for (int i = 0; i < PW; i++) mem_m[(reg_wdata / PB) * PW + i] = '1;
          left = PW + (newpend ? 1 : 0) + 1;
        end
      end else if (reg_addr == A_ALL) begin
        if (!busy && cfg_m[1] && reg_wdata == 1) begin
          foreach (mem_m[i]) mem_m[i] = '1;
          foreach (uc_m[i]) uc_m[i] = '1;
          left = DEPTH + (newpend ? 1 : 0) + 1;
        end
      end else if (reg_addr == A_UC) begin
        if (!busy && reg_wdata == 1) foreach (uc_m[i]) uc_m[i] = '1;
      end else exp_re = 1;
    end
    if (left > 0) left--;
    pend_m = newpend;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("reg_rdata", reg_rdata, exp_rr);
    chk("reg_err", {31'd0, reg_err}, {31'd0, exp_re});
    chk("st_err", {31'd0, st_err}, {31'd0, exp_se});
    chk("uc_rdata", uc_rdata, exp_uc);
    if (st_chk && !$isunknown(exp_st)) chk("st_rdata", st_rdata, exp_st);
    reg_en = 0; reg_we = 0; st_we = 0; uc_en = 0; uc_we = 0;
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d; tick();
  endtask
  task automatic reg_rd(logic [11:0] a);
    reg_en = 1; reg_we = 0; reg_addr = a; tick();
  endtask
  task automatic st_wr(int a, logic [31:0] d);
    st_we = 1; st_addr = WAW'(a); st_wdata = d; tick();
  endtask
  task automatic st_rd(int a, logic [31:0] e);
    st_raddr = WAW'(a); tick(); tick();
    chk($sformatf("word %0d", a), st_rdata, e);
  endtask
  task automatic uc_wr(int a, logic [31:0] d);
    uc_en = 1; uc_we = 1; uc_addr = UAW'(a); uc_wdata = d; tick();
  endtask
  task automatic uc_rd(int a, logic [31:0] e);
    uc_en = 1; uc_we = 0; uc_addr = UAW'(a); tick();
    chk($sformatf("ucfg %0d", a), uc_rdata, e);
  endtask
  task automatic wait_ready();
    for (int i = 0; i < 5000; i++) begin
      reg_rd(A_RDY);
      if (reg_rdata == 32'd1) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst = 0;
    // R9: reset state
    cur_req = "R9";
    reg_rd(A_CFG); chk("cfg after reset", reg_rdata, 32'd0);
    uc_rd(0, 32'hFFFF_FFFF);
    // R1: masked configuration write and read-back
    cur_req = "R1";
    reg_wr(A_CFG, 32'hFFFF_FFFF);
    reg_rd(A_CFG); chk("cfg masked", reg_rdata, 32'd3);
    tick(); chk("rdata idle zero", reg_rdata, 32'd0);
    // R6: wrong key ignored, then full wipe
    cur_req = "R6";
    reg_wr(A_CFG, 32'd2);
    uc_wr(5, 32'h0000_1234);
    reg_wr(A_ALL, 32'd2);
    reg_rd(A_RDY); chk("bad key no sweep", reg_rdata, 32'd1);
    uc_rd(5, 32'h0000_1234);
    reg_wr(A_ALL, 32'd1);
    reg_rd(A_RDY); chk("erase-all busy", reg_rdata, 32'd0);
    wait_ready();
    uc_rd(5, 32'hFFFF_FFFF);
    st_rd(0, 32'hFFFF_FFFF); st_rd(DEPTH - 1, 32'hFFFF_FFFF);
    // R2: AND programming, back-to-back to one word
    cur_req = "R2";
    reg_wr(A_CFG, 32'd1);
    st_wr(10, 32'hF0F0_FFFF);
    st_wr(10, 32'h0FFF_00FF);
    st_wr(11, 32'h1234_5678);
    st_wr(10, 32'hFFFF_FFFF);
    tick();
    st_rd(10, 32'h00F0_00FF); st_rd(11, 32'h1234_5678);
    // R3: locked program
    cur_req = "R3";
    reg_wr(A_CFG, 32'd0);
    st_wr(12, 32'h0);
    chk("st_err pulse", {31'd0, st_err}, 32'd1);
    st_rd(12, 32'hFFFF_FFFF);
    // R4: page erase, blocked then honoured
    cur_req = "R4";
    reg_wr(A_CFG, 32'd1);
    st_wr(300, 32'h0); st_wr(255, 32'h0); st_wr(512, 32'h0); tick();
    reg_wr(A_PG, 32'h0000_05FC);
    reg_rd(A_RDY); chk("no erase without een", reg_rdata, 32'd1);
    st_rd(300, 32'h0);
    reg_wr(A_CFG, 32'd3);
    reg_wr(A_PG, 32'h0000_05FC);
    wait_ready();
    st_rd(300, 32'hFFFF_FFFF); st_rd(255, 32'h0); st_rd(512, 32'h0);
    // R5: out-of-range page address
    cur_req = "R5";
    st_wr(DEPTH - 1, 32'h0); tick();
    reg_wr(A_PG, DEPTH * 4);
    reg_rd(A_RDY); chk("oob ready", reg_rdata, 32'd1);
    st_rd(DEPTH - 1, 32'h0);
    reg_wr(A_PG, DEPTH * 4 - 4);
    wait_ready();
    st_rd(DEPTH - 1, 32'hFFFF_FFFF);
    // R8: commands and programs ignored while busy; same-cycle ordering
    cur_req = "R8";
    uc_wr(3, 32'h0000_00AA);
    reg_wr(A_PG, 32'h0000_0800);
    st_wr(600, 32'h0);
    reg_rd(A_RDY); chk("ready low", reg_rdata, 32'd0);
    reg_wr(A_UC, 32'd1);
    reg_wr(A_ALL, 32'd1);
    wait_ready();
    st_rd(600, 32'hFFFF_FFFF); uc_rd(3, 32'h0000_00AA); st_rd(10, 32'h00F0_00FF);
    st_we = 1; st_addr = WAW'(20); st_wdata = 32'h0;
    reg_en = 1; reg_we = 1; reg_addr = A_PG; reg_wdata = 32'h0000_0800; tick();
    wait_ready();
    st_rd(20, 32'h0);
    st_wr(700, 32'h0); tick();
    st_we = 1; st_addr = WAW'(701); st_wdata = 32'h0;
    reg_en = 1; reg_we = 1; reg_addr = A_PG; reg_wdata = 32'h0000_0800; tick();
    wait_ready();
    st_rd(700, 32'hFFFF_FFFF); st_rd(701, 32'hFFFF_FFFF);
    // R7: user-config erase without erase enable
    cur_req = "R7";
    reg_wr(A_CFG, 32'd0);
    uc_wr(7, 32'h0000_0055);
    reg_wr(A_UC, 32'd0); uc_rd(7, 32'h0000_0055);
    reg_wr(A_UC, 32'd1); uc_rd(7, 32'hFFFF_FFFF); uc_rd(3, 32'hFFFF_FFFF);
    // R10: user-config read/write
    cur_req = "R10";
    uc_wr(0, 32'hDEAD_BEEF); uc_wr(63, 32'h0BAD_F00D);
    uc_rd(0, 32'hDEAD_BEEF); uc_rd(63, 32'h0BAD_F00D);
    tick(); chk("uc idle zero", uc_rdata, 32'd0);
    // R11: undefined offsets
    cur_req = "R11";
    reg_rd(12'h100); chk("undef read err", {31'd0, reg_err}, 32'd1);
    chk("undef read zero", reg_rdata, 32'd0);
    reg_wr(A_RDY, 32'd0); chk("ready write err", {31'd0, reg_err}, 32'd1);
    reg_wr(12'h510, 32'd3); reg_rd(A_CFG); chk("cfg untouched", reg_rdata, 32'd0);
    // R9: storage survives reset
    cur_req = "R9";
    reg_wr(A_CFG, 32'd3);
    st_wr(30, 32'h0); uc_wr(1, 32'h0); tick();
    rst = 1; tick(); tick(); rst = 0;
    reg_rd(A_CFG); chk("cfg cleared", reg_rdata, 32'd0);
    uc_rd(1, 32'hFFFF_FFFF);
    st_rd(30, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule